// File: doc/BRIEF.md
# Multi-Port RAM with Per-Pair Transparency and Write Priority

This block is a single-clock memory with any number of independent write ports and any number of synchronous read ports. Every port has its own enable and address. Every write port also has its own data and a per-bit write mask of the same width as the data. Two parameter bitmasks decide how ports interact when their addresses meet in one cycle.

Every write port has an identifier from 0 up to `NUM_WR-1`. This identifier is its position in the port vectors. The write port with identifier `w` owns field `w` of `WR_PRIO`. A set bit `v` in that field means that port `w` overrides port `v` on the bits both of them enable at the same address. This is a partial order. When two ports with no relation enable the same bit at the same address, the stored value is undefined. Such ports are expected to come from disjoint processes. The read port `r` owns field `r` of `RD_TRANSP`. A set bit `w` in that field means that a same-cycle write from port `w` to the read address is seen on the read data. A clear bit means the read returns the value as it was before that write. Each field is `MASK_BITS` (8) bits wide.

The memory never stalls and has no back-pressure. Each read port has one `rd_valid` pin, which marks the cycle that carries the data for a read issued on the edge before. No ready signal is needed, because every request is accepted when it is presented.

Top module: `xmask_ram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `rd_valid` is 0 and `rd_data` is 0. After reset, every word of the memory reads 0.
- R2: If `rd_en[r]` is high at a clock edge, then after that edge `rd_valid[r]` is 1. `rd_data[r]` then holds the word at `rd_addr[r]` as that edge resolved it. If `rd_en[r]` is low at an edge, `rd_valid[r]` is 0 after it.
- R3: A write changes only the bits whose `wr_bmask` bit is 1. The bit at position b of field w in `wr_bmask` gates bit b of `wr_data` field w. Bits with a mask bit of 0 keep their stored value.
- R4: Write ports that target different addresses in the same cycle all take effect.
- R5: If bit w of read port r's `RD_TRANSP` field is 1 and write port w writes the read address in the same cycle, the read returns the newly written bits.
- R6: If bit w of read port r's `RD_TRANSP` field is 0, the read returns the value stored before port w's same-cycle write. The new value is seen from the next read.
- R7: If bit v of write port w's `WR_PRIO` field is 1 and both ports write the same address, port w's value is stored on every bit that both enable. Port v's value is stored on the bits only port v enables.
- R8: A transparent read that meets several writes to its address follows the same per-bit priority. A write bit that is overridden is not seen, even by a read that is transparent with the losing port.
- R9: While `rd_en[r]` is low, `rd_data[r]` keeps its last value, even when its last address is written.
- R10: The configuration is rejected at elaboration if a priority field sets its own port's bit. It is also rejected if any priority or transparency field sets a bit at or above `NUM_WR`. The package functions that make these tests return 1 exactly for such masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Active-low synchronous reset; clears memory and read outputs |
| wr_en | input | NUM_WR | Enable for each write port |
| wr_addr | input | NUM_WR*AW | Address of each write port, port w in bits [w*AW +: AW] |
| wr_data | input | NUM_WR*DW | Data of each write port, port w in bits [w*DW +: DW] |
| wr_bmask | input | NUM_WR*DW | Per-bit write mask of each write port |
| rd_en | input | NUM_RD | Enable for each read port |
| rd_addr | input | NUM_RD*AW | Address of each read port |
| rd_data | output | NUM_RD*DW | Registered read data of each read port |
| rd_valid | output | NUM_RD | High in the cycle after a read enable |

## Verification
Read data and `rd_valid` are due one clock edge after the edge that samples `rd_en`. A write changes the memory at its own edge, so a read that is not transparent sees the write only when it is issued at the next edge or later. The bench changes inputs at the falling edge. It lets exactly one rising edge pass, then samples at the next falling edge. For that reason, each expected value is compared one edge after its stimulus, and a value that is meant to be held is compared again after further edges.

// File: rtl/xmask_ram_pkg.sv
package xmask_ram_pkg;

  localparam int MASK_BITS = 8;

  // Priority field of port self_id: its own bit and bits beyond the port count are illegal
  function automatic logic prio_mask_bad(input logic [MASK_BITS-1:0] m,
                                         input int self_id, input int n_ports);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < MASK_BITS; i++) begin
      if (m[i] && (i == self_id || i >= n_ports)) bad = 1'b1;
    end
    return bad;
  endfunction

  // Transparency field: bits beyond the write port count are illegal
  function automatic logic transp_mask_bad(input logic [MASK_BITS-1:0] m, input int n_ports);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < MASK_BITS; i++) begin
      if (m[i] && i >= n_ports) bad = 1'b1;
    end
    return bad;
  endfunction

endpackage

// File: rtl/xmask_ram_resolve.sv
// Turns raw per-bit write masks into effective masks after priority is applied.
module xmask_ram_resolve
  import xmask_ram_pkg::*;
#(
  parameter int NUM_WR = 3,
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter logic [NUM_WR*MASK_BITS-1:0] WR_PRIO = '0
) (
  input  logic [NUM_WR-1:0]         wr_en,
  input  logic [NUM_WR-1:0][AW-1:0] wr_addr,
  input  logic [NUM_WR-1:0][DW-1:0] wr_bmask,
  output logic [NUM_WR-1:0][DW-1:0] eff_we
);

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wp
    logic [DW-1:0] kill;
    always_comb begin
      kill = '0;
      for (int v = 0; v < NUM_WR; v++) begin
        // port v overrides port w when v's field carries bit w
        if (v != w && wr_en[v] && WR_PRIO[v*MASK_BITS + w] && wr_addr[v] == wr_addr[w])
          kill = kill | wr_bmask[v];
      end
      eff_we[w] = wr_en[w] ? (wr_bmask[w] & ~kill) : '0;
    end
  end

endmodule

// File: rtl/xmask_ram_store.sv
// Storage array; merges all resolved writes per row and provides pre-write read words.
module xmask_ram_store #(
  parameter int NUM_WR = 3,
  parameter int NUM_RD = 2,
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_WR-1:0][AW-1:0] wr_addr,
  input  logic [NUM_WR-1:0][DW-1:0] wr_data,
  input  logic [NUM_WR-1:0][DW-1:0] eff_we,
  input  logic [NUM_RD-1:0][AW-1:0] rd_addr,
  output logic [NUM_RD-1:0][DW-1:0] rd_old
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    // accumulate so that writes to disjoint bits of one row all land
    for (int w = 0; w < NUM_WR; w++) begin
      mem_d[wr_addr[w]] = (mem_d[wr_addr[w]] & ~eff_we[w]) | (wr_data[w] & eff_we[w]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_RD; r++) rd_old[r] = mem_q[rd_addr[r]];
  end

endmodule

// File: rtl/xmask_ram_rdport.sv
// One synchronous read port; overlays same-cycle writes it is transparent with.
module xmask_ram_rdport
  import xmask_ram_pkg::*;
#(
  parameter int NUM_WR = 3,
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter logic [MASK_BITS-1:0] TMASK = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             old_word,
  input  logic [NUM_WR-1:0][AW-1:0] wr_addr,
  input  logic [NUM_WR-1:0][DW-1:0] wr_data,
  input  logic [NUM_WR-1:0][DW-1:0] eff_we,
  output logic [DW-1:0]             data_q,
  output logic                      valid_q
);

  logic [DW-1:0] seen;

  always_comb begin
    seen = old_word;
    for (int w = 0; w < NUM_WR; w++) begin
      if (TMASK[w] && wr_addr[w] == addr)
        seen = (seen & ~eff_we[w]) | (wr_data[w] & eff_we[w]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en;
      if (en) data_q <= seen;
    end
  end

endmodule

// File: rtl/xmask_ram.sv
module xmask_ram
  import xmask_ram_pkg::*;
#(
  parameter int NUM_WR = 3,
  parameter int NUM_RD = 2,
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  // field w: write ports that port w overrides
  parameter logic [NUM_WR*MASK_BITS-1:0] WR_PRIO   = {8'h02, 8'h00, 8'h02},
  // field r: write ports read port r sees through
  parameter logic [NUM_RD*MASK_BITS-1:0] RD_TRANSP = {8'h02, 8'h07},
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WR-1:0]    wr_en,
  input  logic [NUM_WR*AW-1:0] wr_addr,
  input  logic [NUM_WR*DW-1:0] wr_data,
  input  logic [NUM_WR*DW-1:0] wr_bmask,
  input  logic [NUM_RD-1:0]    rd_en,
  input  logic [NUM_RD*AW-1:0] rd_addr,
  output logic [NUM_RD*DW-1:0] rd_data,
  output logic [NUM_RD-1:0]    rd_valid
);

  // R10: configuration checks at elaboration
  if (NUM_WR > MASK_BITS) begin : g_bad_count
    $error("xmask_ram: NUM_WR exceeds mask field width");
  end
  for (genvar w = 0; w < NUM_WR; w++) begin : g_chk_prio
    if (prio_mask_bad(WR_PRIO[w*MASK_BITS +: MASK_BITS], w, NUM_WR)) begin : g_bad
      $error("xmask_ram: illegal priority field for write port %0d", w);
    end
  end
  for (genvar r = 0; r < NUM_RD; r++) begin : g_chk_tr
    if (transp_mask_bad(RD_TRANSP[r*MASK_BITS +: MASK_BITS], NUM_WR)) begin : g_bad
      $error("xmask_ram: illegal transparency field for read port %0d", r);
    end
  end

  logic [NUM_WR-1:0][AW-1:0] wa;
  logic [NUM_WR-1:0][DW-1:0] wd;
  logic [NUM_WR-1:0][DW-1:0] wm;
  logic [NUM_WR-1:0][DW-1:0] eff_we;
  logic [NUM_RD-1:0][AW-1:0] ra;
  logic [NUM_RD-1:0][DW-1:0] old_words;

  assign wa = wr_addr;
  assign wd = wr_data;
  assign wm = wr_bmask;
  assign ra = rd_addr;

  xmask_ram_resolve #(
    .NUM_WR(NUM_WR), .DW(DW), .AW(AW), .WR_PRIO(WR_PRIO)
  ) u_resolve (
    .wr_en(wr_en), .wr_addr(wa), .wr_bmask(wm), .eff_we(eff_we)
  );

  xmask_ram_store #(
    .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .DW(DW), .DEPTH(DEPTH)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_addr(wa), .wr_data(wd), .eff_we(eff_we),
    .rd_addr(ra), .rd_old(old_words)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rp
    xmask_ram_rdport #(
      .NUM_WR(NUM_WR), .DW(DW), .AW(AW),
      .TMASK(RD_TRANSP[r*MASK_BITS +: MASK_BITS])
    ) u_rp (
      .clk(clk), .rst_n(rst_n), .en(rd_en[r]), .addr(ra[r]),
      .old_word(old_words[r]), .wr_addr(wa), .wr_data(wd), .eff_we(eff_we),
      .data_q(rd_data[r*DW +: DW]), .valid_q(rd_valid[r])
    );
  end

endmodule

// File: rtl/xmask_ram_chk.sv
module xmask_ram_chk
  import xmask_ram_pkg::*;
#(
  parameter int NUM_WR = 3,
  parameter int NUM_RD = 2,
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter logic [NUM_RD*MASK_BITS-1:0] RD_TRANSP = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WR-1:0]    wr_en,
  input logic [NUM_WR*AW-1:0] wr_addr,
  input logic [NUM_WR*DW-1:0] wr_data,
  input logic [NUM_WR*DW-1:0] wr_bmask,
  input logic [NUM_RD-1:0]    rd_en,
  input logic [NUM_RD*AW-1:0] rd_addr,
  input logic [NUM_RD*DW-1:0] rd_data,
  input logic [NUM_RD-1:0]    rd_valid
);

  for (genvar r = 0; r < NUM_RD; r++) begin : g_r
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_valid[r] == 1'b0 && rd_data[r*DW +: DW] == '0));

    p_valid_follows_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[r] |=> rd_valid[r]);

    p_no_valid_without_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[r] |=> !rd_valid[r]);

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[r] |=> $stable(rd_data[r*DW +: DW]));

    for (genvar w = 0; w < NUM_WR; w++) begin : g_w
      if (RD_TRANSP[r*MASK_BITS + w]) begin : g_t
        // R5: lone full-width write seen by a transparent read at the same address
        p_see_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_en[r] && wr_en == (NUM_WR'(1) << w)
           && wr_addr[w*AW +: AW] == rd_addr[r*AW +: AW]
           && (&wr_bmask[w*DW +: DW]))
          |=> rd_data[r*DW +: DW] == $past(wr_data[w*DW +: DW]));
      end
    end
  end

endmodule

bind xmask_ram xmask_ram_chk #(
  .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .DW(DW), .AW(AW), .RD_TRANSP(RD_TRANSP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_bmask(wr_bmask), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .rd_valid(rd_valid)
);

// File: tb/xmask_ram_tb_top.sv
`timescale 1ns/1ps
module xmask_ram_tb_top;
  import xmask_ram_pkg::*;

  localparam int NW = 3, NR = 2, DW = 8, DEPTH = 16, AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]    wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NW*DW-1:0] wr_bmask = '0;
  logic [NR-1:0]    rd_en = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;
  logic [NR-1:0]    rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xmask_ram dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bmask(wr_bmask), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = '0; rd_en = '0; wr_bmask = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_wr(input int w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] m);
    wr_en[w] = 1'b1;
    wr_addr[w*AW +: AW] = a;
    wr_data[w*DW +: DW] = d;
    wr_bmask[w*DW +: DW] = m;
  endtask

  task automatic set_rd(input int r, input logic [AW-1:0] a);
    rd_en[r] = 1'b1;
    rd_addr[r*AW +: AW] = a;
  endtask

  function automatic logic [DW-1:0] rdw(input int r);
    return rd_data[r*DW +: DW];
  endfunction

  task automatic read_chk(input string req, input int r, input logic [AW-1:0] a,
                          input logic [DW-1:0] exp);
    idle(); set_rd(r, a); step();
    chk(req, rdw(r), exp);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", rd_valid, '0);
    chk("R1 data in reset", rd_data, '0);
    rst_n = 1'b1;
    step();
    chk("R1 valid after release", rd_valid, '0);
    read_chk("R1 cleared word", 0, 4'd5, 8'h00);
  endtask

  task automatic t_basic();
    idle(); set_wr(0, 4'd3, 8'hA5, 8'hFF); step();
    idle(); set_rd(0, 4'd3); set_rd(1, 4'd3); step();
    chk("R2 read port 0", rdw(0), 8'hA5);
    chk("R2 read port 1", rdw(1), 8'hA5);
    chk("R2 valid", rd_valid, 2'b11);
    idle(); step();
    chk("R2 valid drops", rd_valid, 2'b00);
  endtask

  task automatic t_mask();
    idle(); set_wr(1, 4'd3, 8'h0F, 8'h0F); step();
    read_chk("R3 masked bits kept", 0, 4'd3, 8'hAF);
  endtask

  task automatic t_multi();
    idle(); set_wr(0, 4'd1, 8'h11, 8'hFF); set_wr(1, 4'd2, 8'h22, 8'hFF);
    set_wr(2, 4'd4, 8'h44, 8'hFF); step();
    read_chk("R4 port 0 word", 1, 4'd1, 8'h11);
    read_chk("R4 port 1 word", 0, 4'd2, 8'h22);
    read_chk("R4 port 2 word", 1, 4'd4, 8'h44);
  endtask

  task automatic t_transp();
    idle(); set_wr(0, 4'd6, 8'h3C, 8'hFF); set_rd(0, 4'd6); step();
    chk("R5 read 0 sees write 0", rdw(0), 8'h3C);
    idle(); set_wr(1, 4'd7, 8'h5A, 8'hFF); set_rd(1, 4'd7); step();
    chk("R5 read 1 sees write 1", rdw(1), 8'h5A);
    idle();
  endtask

  task automatic t_opaque();
    idle(); set_wr(0, 4'd6, 8'hC3, 8'hFF); set_rd(1, 4'd6); step();
    chk("R6 read 1 gets old word", rdw(1), 8'h3C);
    read_chk("R6 next read gets new word", 1, 4'd6, 8'hC3);
  endtask

  task automatic t_prio();
    // port 0 beats 1, port 2 beats 1, ports 0 and 2 unrelated but on disjoint bits
    idle();
    set_wr(0, 4'd8, 8'hFF, 8'h0F);
    set_wr(1, 4'd8, 8'h00, 8'hFF);
    set_wr(2, 4'd8, 8'hAA, 8'hF0);
    set_rd(0, 4'd8); set_rd(1, 4'd8);
    step();
    chk("R8 all-transparent read follows winners", rdw(0), 8'hAF);
    chk("R8 read through loser only sees old word", rdw(1), 8'h00);
    read_chk("R7 stored winners", 1, 4'd8, 8'hAF);
    idle(); set_wr(0, 4'd9, 8'h11, 8'h0F); set_wr(1, 4'd9, 8'h22, 8'hFF); step();
    read_chk("R7 loser keeps unshared bits", 0, 4'd9, 8'h21);
  endtask

  task automatic t_hold();
    idle(); set_rd(0, 4'd2); step();
    chk("R9 setup read", rdw(0), 8'h22);
    idle(); set_wr(0, 4'd2, 8'h99, 8'hFF); step();
    chk("R9 data held", rdw(0), 8'h22);
    chk("R9 valid low", rd_valid[0], 1'b0);
    step();
    chk("R9 still held", rdw(0), 8'h22);
  endtask

  task automatic t_cfg();
    chk("R10 legal priority", prio_mask_bad(8'h02, 0, 3), 1'b0);
    chk("R10 self priority", prio_mask_bad(8'h01, 0, 3), 1'b1);
    chk("R10 missing port priority", prio_mask_bad(8'h08, 1, 3), 1'b1);
    chk("R10 legal transparency", transp_mask_bad(8'h07, 3), 1'b0);
    chk("R10 missing port transparency", transp_mask_bad(8'h10, 3), 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_multi();
    t_transp();
    t_opaque();
    t_prio();
    t_hold();
    t_cfg();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule